// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single counting semaphore held in a register that software reaches through ordinary loads and stores. A load through one of the take views acts as the P operation. It returns the count and, when the count is non-zero, lowers it by one. A store through one of the give views acts as the V operation. It raises the count, stopping at the largest value, and the stored data plays no part. Each take view comes in two flavours. The blocking flavour reports a stall when there is nothing to take. The try flavour simply returns zero.

Each read carries a requester id. A blocking take that finds the count empty records its requester in a waiter mask. The next give emits a one-cycle wake pulse that carries that mask, and the mask is then cleared. A woken requester is not granted anything automatically. It must reissue its take, and it competes for the count again. A raw view reads the count without touching it. Stores through the raw view are dropped. Address decoding and the bus protocol sit outside the block. The block sees one read request port and one write request port, and both may be active in the same cycle.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the waiter mask is empty, and rd_ack and wake_valid are low.
- R2: A take (rd_view 1 = blocking, 2 = try) that finds a non-zero count returns the count before the access on rd_data, with rd_stall low, and leaves the count one lower. rd_ack is high in the cycle after every accepted read request and low otherwise.
- R3: A try take (rd_view 2) that finds the count at 0 returns 0 with rd_stall low. The count and the waiter mask stay unchanged.
- R4: A blocking take (rd_view 1) that finds the count at 0 returns rd_stall high and rd_data 0, sets bit rd_id of the waiter mask, and leaves the count at 0.
- R5: A give (wr_view 1 = blocking, 2 = try; both behave the same) adds 1 to the count while it is below the all-ones value (0xFFFF by default) and holds it there once reached. wr_data has no effect.
- R6: A give that finds a non-empty waiter mask raises wake_valid for exactly one cycle, the cycle after the give, with wake_mask equal to that mask, and empties the mask. A give with an empty mask leaves wake_valid low.
- R7: A raw read (rd_view 0) returns the count and changes nothing. A raw write (wr_view 0) and the reserved write view 3 change nothing.
- R8: When a give and a take arrive in the same cycle, the give is applied first. The take sees the incremented count, so it cannot stall.
- R9: A woken requester must reissue its take. With one give and two woken waiters, the first reissue succeeds exactly once and the second stalls again and re-enters the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Read request this cycle |
| rd_view | input | 2 | Read view: 0 raw, 1 blocking take, 2 try take, 3 reserved |
| rd_id | input | ID_W | Requester id of the read |
| wr_valid | input | 1 | Write request this cycle |
| wr_view | input | 2 | Write view: 0 raw (dropped), 1 blocking give, 2 try give, 3 reserved |
| wr_data | input | CNT_W | Store data, ignored |
| rd_ack | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | CNT_W | Read response value |
| rd_stall | output | 1 | Blocking take found nothing; requester must wait for a wake |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | NUM_REQ | Requesters being woken |

## Verification
The assertions assume that the request views are driven with their encoded values while valid. They also assume that the requester id is below NUM_REQ, and that inputs are stable around the clock edge. The stimulus drives every request on the falling edge and releases it just after the rising edge. It uses only ids 0 to 7 with the default eight requesters. It never leaves a valid request raised across more than the one intended edge. The count and mask properties are only armed when a single port is active, so the same-cycle give/take case is checked by the bench alone.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
   typedef enum logic [1:0] {
      RD_RAW     = 2'd0,
      RD_P_BLOCK = 2'd1,
      RD_P_TRY   = 2'd2,
      RD_RSVD    = 2'd3
   } rd_view_e;

   typedef enum logic [1:0] {
      WR_RAW     = 2'd0,
      WR_V_BLOCK = 2'd1,
      WR_V_TRY   = 2'd2,
      WR_RSVD    = 2'd3
   } wr_view_e;

   typedef struct packed {
      logic take;
      logic take_block;
      logic raw_rd;
      logic give;
   } sem_op_t;
endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
   import sem_cell_pkg::*;
(
   input  logic       rd_valid,
   input  logic [1:0] rd_view,
   input  logic       wr_valid,
   input  logic [1:0] wr_view,
   output sem_op_t    op
);
   rd_view_e rv;
   wr_view_e wv;

   always_comb begin
      rv = rd_view_e'(rd_view);
      wv = wr_view_e'(wr_view);
      op = '0;
      if (rd_valid) begin
         unique case (rv)
            RD_RAW:     op.raw_rd = 1'b1;
            RD_P_BLOCK: begin op.take = 1'b1; op.take_block = 1'b1; end
            RD_P_TRY:   op.take = 1'b1;
            default:    ;
         endcase
      end
      if (wr_valid && (wv == WR_V_BLOCK || wv == WR_V_TRY))
         op.give = 1'b1;
   end
endmodule

// File: rtl/sem_count_core.sv
module sem_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             give,
   input  logic             take,
   input  logic             take_block,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] seen_val,
   output logic             take_ok,
   output logic             take_stall
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] after_give;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      after_give = (give && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
      seen_val   = after_give;
      take_ok    = take && (after_give != '0);
      take_stall = take && take_block && (after_give == '0);
      cnt_d      = take_ok ? after_give - 1'b1 : after_give;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/sem_waiter_set.sv
module sem_waiter_set #(
   parameter int NUM_REQ = 8,
   parameter int ID_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall,
   input  logic [ID_W-1:0]    stall_id,
   input  logic               give,
   output logic [NUM_REQ-1:0] mask_q,
   output logic               wake_valid,
   output logic [NUM_REQ-1:0] wake_mask
);
   logic [NUM_REQ-1:0] mask_d;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
      always_comb
         mask_d[i] = (give ? 1'b0 : mask_q[i]) |
                     (stall && stall_id == ID_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         wake_valid <= 1'b0;
         wake_mask  <= '0;
      end else begin
         mask_q     <= mask_d;
         wake_valid <= give && (mask_q != '0);
         wake_mask  <= give ? mask_q : '0;
      end
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_cell_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_REQ = 8,
   parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_valid,
   input  logic [1:0]         rd_view,
   input  logic [ID_W-1:0]    rd_id,
   input  logic               wr_valid,
   input  logic [1:0]         wr_view,
   input  logic [CNT_W-1:0]   wr_data,
   output logic               rd_ack,
   output logic [CNT_W-1:0]   rd_data,
   output logic               rd_stall,
   output logic               wake_valid,
   output logic [NUM_REQ-1:0] wake_mask
);
   if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
      $error("sem_cell: CNT_W out of range");
   end
   if (NUM_REQ < 1 || (1 << ID_W) < NUM_REQ) begin : g_bad_req
      $error("sem_cell: NUM_REQ does not fit ID_W");
   end

   sem_op_t          op;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] seen_val;
   logic             take_ok;
   logic             take_stall;
   logic [NUM_REQ-1:0] mask_q;
   logic             unused_wr_data;

   assign unused_wr_data = ^wr_data;

   sem_view_decode u_dec (
      .rd_valid (rd_valid),
      .rd_view  (rd_view),
      .wr_valid (wr_valid),
      .wr_view  (wr_view),
      .op       (op)
   );

   sem_count_core #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .give       (op.give),
      .take       (op.take),
      .take_block (op.take_block),
      .cnt_q      (cnt_q),
      .seen_val   (seen_val),
      .take_ok    (take_ok),
      .take_stall (take_stall)
   );

   sem_waiter_set #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall      (take_stall),
      .stall_id   (rd_id),
      .give       (op.give),
      .mask_q     (mask_q),
      .wake_valid (wake_valid),
      .wake_mask  (wake_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ack   <= 1'b0;
         rd_data  <= '0;
         rd_stall <= 1'b0;
      end else begin
         rd_ack   <= rd_valid;
         rd_data  <= (op.raw_rd || take_ok) ? seen_val : '0;
         rd_stall <= take_stall;
      end
   end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk
   import sem_cell_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_REQ = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_valid,
   input logic [1:0]         rd_view,
   input logic               wr_valid,
   input logic [1:0]         wr_view,
   input logic               rd_ack,
   input logic [CNT_W-1:0]   rd_data,
   input logic               rd_stall,
   input logic               wake_valid,
   input logic [NUM_REQ-1:0] wake_mask,
   input logic [CNT_W-1:0]   cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic is_take, is_give;
   assign is_take = rd_valid && (rd_view == RD_P_BLOCK || rd_view == RD_P_TRY);
   assign is_give = wr_valid && (wr_view == WR_V_BLOCK || wr_view == WR_V_TRY);

   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_ack);
   assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_ack);
   assert_take_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_take && !wr_valid && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && !rd_stall);
   assert_try_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_view == RD_P_TRY && !wr_valid && cnt_q == '0) |=> (cnt_q == '0) && !rd_stall && rd_data == '0);
   assert_stall_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stall |-> rd_ack && rd_data == '0);
   assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_give && !rd_valid && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
   assert_wake_has_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> wake_mask != '0);
   assert_wake_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |=> !wake_valid);
   assert_raw_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_view == RD_RAW && !wr_valid) |=> $stable(cnt_q) && rd_data == cnt_q);
   assert_give_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_take && is_give) |=> !rd_stall);
endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_valid   (rd_valid),
   .rd_view    (rd_view),
   .wr_valid   (wr_valid),
   .wr_view    (wr_view),
   .rd_ack     (rd_ack),
   .rd_data    (rd_data),
   .rd_stall   (rd_stall),
   .wake_valid (wake_valid),
   .wake_mask  (wake_mask),
   .cnt_q      (cnt_q)
);

// File: tb/sem_cell_tb_top.sv
module sem_cell_tb_top;
   localparam int CNT_W   = 16;
   localparam int NUM_REQ = 8;
   localparam int ID_W    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_valid = 1'b0;
   logic [1:0] rd_view = '0;
   logic [ID_W-1:0] rd_id = '0;
   logic wr_valid = 1'b0;
   logic [1:0] wr_view = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic rd_ack, rd_stall, wake_valid;
   logic [CNT_W-1:0] rd_data;
   logic [NUM_REQ-1:0] wake_mask;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   sem_cell #(.CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
      .wr_valid(wr_valid), .wr_view(wr_view), .wr_data(wr_data),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_stall(rd_stall),
      .wake_valid(wake_valid), .wake_mask(wake_mask)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one bus cycle: drive at falling edge, sample just after the rising edge
   task automatic step(input logic rv, input logic [1:0] rview, input logic [ID_W-1:0] rid,
                       input logic wv, input logic [1:0] wview, input logic [CNT_W-1:0] wd);
      @(negedge clk);
      rd_valid = rv; rd_view = rview; rd_id = rid;
      wr_valid = wv; wr_view = wview; wr_data = wd;
      @(posedge clk);
      #1;
      rd_valid = 1'b0; wr_valid = 1'b0;
   endtask

   task automatic take(input logic blk, input logic [ID_W-1:0] id);
      step(1'b1, blk ? 2'd1 : 2'd2, id, 1'b0, 2'd0, '0);
   endtask
   task automatic give(input logic blk, input logic [CNT_W-1:0] d);
      step(1'b0, 2'd0, '0, 1'b1, blk ? 2'd1 : 2'd2, d);
   endtask
   task automatic raw_count(output logic [CNT_W-1:0] v);
      step(1'b1, 2'd0, '0, 1'b0, 2'd0, '0);
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [CNT_W-1:0] v;
      chk("R1 rd_ack after reset", 32'(rd_ack), 0);
      chk("R1 wake_valid after reset", 32'(wake_valid), 0);
      raw_count(v);
      chk("R1 count after reset", 32'(v), 0);
      give(1'b1, 16'h1234);
      chk("R1 empty mask gives no wake", 32'(wake_valid), 0);
      take(1'b0, 0);
   endtask

   task automatic t_give_raw();
      logic [CNT_W-1:0] v;
      give(1'b1, 16'hFFFF);
      give(1'b0, 16'h0000);
      give(1'b1, 16'hA5A5);
      raw_count(v);
      chk("R5 three gives, data ignored", 32'(v), 3);
      step(1'b0, 2'd0, '0, 1'b1, 2'd0, 16'h0077);
      raw_count(v);
      chk("R7 raw write ignored", 32'(v), 3);
      step(1'b0, 2'd0, '0, 1'b1, 2'd3, 16'h0001);
      raw_count(v);
      chk("R7 reserved write ignored", 32'(v), 3);
   endtask

   task automatic t_take();
      logic [CNT_W-1:0] v;
      take(1'b1, 3);
      chk("R2 blocking take ack", 32'(rd_ack), 1);
      chk("R2 blocking take value", 32'(rd_data), 3);
      chk("R2 blocking take no stall", 32'(rd_stall), 0);
      take(1'b0, 4);
      chk("R2 try take value", 32'(rd_data), 2);
      raw_count(v);
      chk("R2 count after two takes", 32'(v), 1);
      take(1'b0, 4);
      chk("R2 last token", 32'(rd_data), 1);
   endtask

   task automatic t_try_empty();
      logic [CNT_W-1:0] v;
      take(1'b0, 6);
      chk("R3 try empty data", 32'(rd_data), 0);
      chk("R3 try empty no stall", 32'(rd_stall), 0);
      raw_count(v);
      chk("R3 try empty count", 32'(v), 0);
      give(1'b0, '0);
      chk("R3 try empty left mask clear", 32'(wake_valid), 0);
      take(1'b0, 6);
      chk("R3 restore count", 32'(rd_data), 1);
   endtask

   task automatic t_block_wake_retry();
      logic [CNT_W-1:0] v;
      take(1'b1, 2);
      chk("R4 stall flagged", 32'(rd_stall), 1);
      chk("R4 stall data", 32'(rd_data), 0);
      take(1'b1, 5);
      chk("R4 second stall", 32'(rd_stall), 1);
      raw_count(v);
      chk("R4 count stays 0", 32'(v), 0);
      give(1'b1, '0);
      chk("R6 wake pulse", 32'(wake_valid), 1);
      chk("R6 wake mask", 32'(wake_mask), 32'h24);
      raw_count(v);
      chk("R6 wake lasts one cycle", 32'(wake_valid), 0);
      take(1'b1, 2);
      chk("R9 first retry succeeds", 32'(rd_data), 1);
      chk("R9 first retry no stall", 32'(rd_stall), 0);
      take(1'b1, 5);
      chk("R9 second retry stalls again", 32'(rd_stall), 1);
      give(1'b0, '0);
      chk("R9 re-entered mask only", 32'(wake_mask), 32'h20);
      take(1'b1, 5);
      chk("R9 later retry succeeds", 32'(rd_data), 1);
      give(1'b1, '0);
      chk("R6 mask cleared after wake", 32'(wake_valid), 0);
      take(1'b0, 0);
   endtask

   task automatic t_same_cycle();
      logic [CNT_W-1:0] v;
      step(1'b1, 2'd1, 3'd1, 1'b1, 2'd2, 16'h0);
      chk("R8 give first, no stall", 32'(rd_stall), 0);
      chk("R8 take sees given token", 32'(rd_data), 1);
      raw_count(v);
      chk("R8 count after pair", 32'(v), 0);
      step(1'b1, 2'd0, '0, 1'b1, 2'd1, 16'h0);
      chk("R8 raw read sees give", 32'(rd_data), 1);
      take(1'b0, 0);
   endtask

   task automatic t_saturate();
      logic [CNT_W-1:0] v;
      for (int i = 0; i < 65535; i++) give(i[0], '0);
      raw_count(v);
      chk("R5 reach max", 32'(v), 32'hFFFF);
      give(1'b1, '0);
      give(1'b0, '0);
      raw_count(v);
      chk("R5 saturates at max", 32'(v), 32'hFFFF);
      take(1'b0, 1);
      chk("R5 take at max", 32'(rd_data), 32'hFFFF);
      raw_count(v);
      chk("R5 count below max", 32'(v), 32'hFFFE);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_give_raw();
      t_take();
      t_try_empty();
      t_block_wake_retry();
      t_same_cycle();
      t_saturate();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait (cycles >= 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule